// File: doc/BRIEF.md
# SCL Clock Divider

This block is the time base for an I2C controller. It takes a prescale code and a fine divider code from one configuration word, and a trim count from a separate input. From these it produces a one-cycle tick strobe at the rate of the internal clock, where the internal clock is the peripheral clock divided by one plus the prescale code. It also produces two phase enables. They tell the master controller when to hold SCL low and when to release it.

One SCL period is 20 + 8·G + T internal ticks, where G is the fine divider code and T is the trim count. T covers the SCL rise time, the fall time and the internal delay. The low phase takes the larger half of the period. While the controller has released SCL, the high phase advances only on ticks where the sampled line is actually high. A slave that stretches the clock therefore lengthens the period by the number of ticks it holds the line low. The block stays quiet from reset until the first configuration write. Every later write restarts the time base in the low phase.

Top module: `scl_clk_div`

## Requirements
- R1: From reset until the first cycle with `cfg_wr` high, `tick`, `phase_low` and `phase_high` are all 0.
- R2: A write captures the prescale code P from `cfg_word[PRE_W-1:0]` and the fine divider code G from `cfg_word[PRE_W+SCGD_W-1:PRE_W]` (the bits directly above P). It captures the trim count T from `cfg_trim` in the same cycle. With the default PRE_W = 3, P ranges from 0 to 7 and G from 0 to 63.
- R3: While running, `tick` is high for exactly one cycle out of every P+1 clock cycles.
- R4: With N = 20 + 8·G + T, a low phase lasts ceil(N/2) ticks and an unstretched high phase lasts floor(N/2) ticks. The phases alternate low, high, low, and so on.
- R5: In the cycle after a write, `phase_low` is 1 and `phase_high` is 0, and the prescaler restarts from zero. This also holds when the write arrives mid-period.
- R6: During the high phase, only ticks on which `scl_in` is 1 count toward the high length. Every tick with `scl_in` at 0 lengthens the period by one tick, so a period with K stretched ticks lasts (N+K)·(P+1) clock cycles.
- R7: `phase_low` and `phase_high` are never both 1. They change only in the cycle after a tick or after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle write strobe for the configuration |
| cfg_word | input | PRE_W+SCGD_W | Prescale code in the low bits, fine divider code above it |
| cfg_trim | input | TRIM_W | Trim ticks added to each period |
| scl_in | input | 1 | Synchronised SCL line level |
| tick | output | 1 | Internal clock strobe, one cycle wide |
| phase_low | output | 1 | Controller must drive SCL low |
| phase_high | output | 1 | Controller must release SCL |

## Verification
The embedded properties check four things on every cycle:
- Tick spacing when the prescale code is non-zero.
- The phase counter stays inside the current phase length.
- The high-phase counter freezes while the line is held low.
- The phase outputs are exclusive, move only after a tick or a write, and return to the low phase after a write.

Only the bench scenarios can show the absolute figures: low and high tick counts for even and odd periods, total period length in clock cycles with and without stretching, correct field placement in the configuration word, and silence before the first write.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/100ps
package scl_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // fixed part of an SCL period and the weight of one fine-divider step
    localparam int unsigned BASE_TICKS = 20;
    localparam int unsigned FINE_STEP  = 8;

endpackage

// File: rtl/scl_div_prescale.sv
`timescale 1ns/100ps
module scl_div_prescale #(
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_code,
    output logic             tick_o
);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d.run = 1'b1;
            pre_d.cnt = '0;
        end else if (pre_q.run) begin
            if (pre_q.cnt == pre_code) begin
                pre_d.cnt = '0;
            end else begin
                pre_d.cnt = pre_q.cnt + PRE_W'(1);
            end
        end
    end

    assign tick_o = pre_q.run && (pre_q.cnt == pre_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R3: a tick is never followed directly by another unless the divide is by one
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart && (pre_code != '0)) |=> !tick_o);

endmodule

// File: rtl/scl_div_phase.sv
`timescale 1ns/100ps
module scl_div_phase
    import scl_div_pkg::*;
#(
    parameter int unsigned PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic             scl_in,
    input  logic [PER_W-1:0] lo_len,
    input  logic [PER_W-1:0] hi_len,
    output logic             phase_low,
    output logic             phase_high
);

    typedef struct packed {
        phase_e           ph;
        logic [PER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.ph  = PH_LOW;
            tmr_d.cnt = '0;
        end else begin
            unique case (tmr_q.ph)
                PH_LOW: begin
                    if (tick) begin
                        if (tmr_q.cnt == lo_len - PER_W'(1)) begin
                            tmr_d.ph  = PH_HIGH;
                            tmr_d.cnt = '0;
                        end else begin
                            tmr_d.cnt = tmr_q.cnt + PER_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    // a line still held low by another device does not advance the count
                    if (tick && scl_in) begin
                        if (tmr_q.cnt == hi_len - PER_W'(1)) begin
                            tmr_d.ph  = PH_LOW;
                            tmr_d.cnt = '0;
                        end else begin
                            tmr_d.cnt = tmr_q.cnt + PER_W'(1);
                        end
                    end
                end
                default: begin
                    tmr_d = tmr_q;
                end
            endcase
        end
    end

    assign phase_low  = (tmr_q.ph == PH_LOW);
    assign phase_high = (tmr_q.ph == PH_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R4: the counter stays inside the active phase length
    a_r4_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.ph == PH_LOW) |-> (tmr_q.cnt < lo_len));
    a_r4_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.ph == PH_HIGH) |-> (tmr_q.cnt < hi_len));

    // R6: a stretched line freezes the high count and keeps the phase
    a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_q.ph == PH_HIGH) && !scl_in && !restart) |=> ($stable(tmr_q.cnt) && phase_high));

endmodule

// File: rtl/scl_clk_div.sv
`timescale 1ns/100ps
module scl_clk_div
    import scl_div_pkg::*;
#(
    parameter int unsigned PRE_W  = 3,
    parameter int unsigned SCGD_W = 6,
    parameter int unsigned TRIM_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [PRE_W+SCGD_W-1:0] cfg_word,
    input  logic [TRIM_W-1:0]       cfg_trim,
    input  logic                    scl_in,
    output logic                    tick,
    output logic                    phase_low,
    output logic                    phase_high
);

    localparam int unsigned CFG_W   = PRE_W + SCGD_W;
    localparam int unsigned PER_MAX = BASE_TICKS + FINE_STEP * ((1 << SCGD_W) - 1)
                                      + (1 << TRIM_W) - 1;
    localparam int unsigned PER_W   = $clog2(PER_MAX + 2);

    typedef struct packed {
        logic              armed;
        logic [PRE_W-1:0]  pre;
        logic [SCGD_W-1:0] fine;
        logic [TRIM_W-1:0] trim;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [PER_W-1:0] per_ticks;
    logic [PER_W-1:0] lo_len;
    logic [PER_W-1:0] hi_len;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.armed = 1'b1;
            cfg_d.pre   = cfg_word[PRE_W-1:0];
            cfg_d.fine  = cfg_word[CFG_W-1:PRE_W];
            cfg_d.trim  = cfg_trim;
        end
    end

    always_comb begin
        per_ticks = PER_W'(BASE_TICKS) + PER_W'(cfg_q.fine) * PER_W'(FINE_STEP)
                    + PER_W'(cfg_q.trim);
        // low half takes the extra tick of an odd period
        lo_len    = (per_ticks + PER_W'(1)) >> 1;
        hi_len    = per_ticks >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    scl_div_prescale #(
        .PRE_W (PRE_W)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cfg_wr),
        .pre_code (cfg_q.pre),
        .tick_o   (tick)
    );

    scl_div_phase #(
        .PER_W (PER_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_wr),
        .tick       (tick),
        .scl_in     (scl_in),
        .lo_len     (lo_len),
        .hi_len     (hi_len),
        .phase_low  (phase_low),
        .phase_high (phase_high)
    );

    // R1: nothing moves before the configuration is written
    a_r1_quiet_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.armed |-> (!tick && !phase_low && !phase_high));

    // R5: a write always lands in the low phase
    a_r5_write_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (phase_low && !phase_high));

    // R7: phase outputs are exclusive and move only after a tick or a write
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phase_low, phase_high}));
    a_r7_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_wr) |=> ($stable(phase_low) && $stable(phase_high)));

endmodule

// File: tb/scl_clk_div_tb.sv
`timescale 1ns/100ps
module scl_clk_div_tb;

    localparam int PRE_W  = 3;
    localparam int SCGD_W = 6;
    localparam int TRIM_W = 6;
    localparam int CFG_W  = PRE_W + SCGD_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic [TRIM_W-1:0] cfg_trim = '0;
    logic             hold = 1'b0;
    logic             scl_in;
    logic             tick, phase_low, phase_high;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // open-drain line model: released by the controller, pulled low while a slave stretches
    assign scl_in = phase_high & ~hold;

    scl_clk_div #(.PRE_W(PRE_W), .SCGD_W(SCGD_W), .TRIM_W(TRIM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .cfg_trim(cfg_trim), .scl_in(scl_in), .tick(tick),
        .phase_low(phase_low), .phase_high(phase_high)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lo(input int g, input int t);
        return (20 + 8 * g + t + 1) / 2;
    endfunction

    function automatic int exp_hi(input int g, input int t);
        return (20 + 8 * g + t) / 2;
    endfunction

    task automatic run_case(input int p, input int g, input int t, input int k, input int nper);
        int  cyc, per_start, lo_t, hi_t, st_t, done, last_tick, gap_bad, seq_bad;
        logic prev_low, prev_high, prev_tick;
        @(negedge clk);
        cfg_word = CFG_W'((g << PRE_W) | p);
        cfg_trim = TRIM_W'(t);
        cfg_wr   = 1'b1;
        hold     = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        chk(phase_low === 1'b1 && phase_high === 1'b0, "R5 low phase after write",
            {30'd0, phase_low, phase_high}, 2);
        cyc = 0; per_start = 0; lo_t = 0; hi_t = 0; st_t = 0; done = 0;
        last_tick = -1; gap_bad = 0; seq_bad = 0;
        while (done < nper) begin
            hold = phase_high && (st_t < k);
            #0.5;
            if (tick) begin
                if (last_tick >= 0 && (cyc - last_tick) != p + 1) gap_bad++;
                last_tick = cyc;
                if (phase_low) lo_t++;
                else if (phase_high && scl_in) hi_t++;
                else if (phase_high) st_t++;
            end
            if (phase_low && phase_high) seq_bad++;
            prev_low  = phase_low;
            prev_high = phase_high;
            prev_tick = tick;
            @(negedge clk);
            #1;
            cyc++;
            if ((phase_low != prev_low || phase_high != prev_high) && !prev_tick) seq_bad++;
            if (prev_high && phase_low) begin
                chk(lo_t == exp_lo(g, t), "R4 low phase ticks", lo_t, exp_lo(g, t));
                chk(hi_t == exp_hi(g, t), "R4 high phase ticks", hi_t, exp_hi(g, t));
                chk((cyc - per_start) == (exp_lo(g, t) + exp_hi(g, t) + k) * (p + 1),
                    "R6 period cycles", cyc - per_start,
                    (exp_lo(g, t) + exp_hi(g, t) + k) * (p + 1));
                lo_t = 0; hi_t = 0; st_t = 0;
                per_start = cyc;
                done++;
            end
        end
        hold = 1'b0;
        chk(gap_bad == 0, "R3 tick spacing", gap_bad, 0);
        chk(seq_bad == 0, "R7 phase moves only after tick", seq_bad, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int busy;
        void'($urandom(32'd31415));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: silent until configured
        busy = 0;
        repeat (40) begin
            @(negedge clk);
            #1;
            if (tick || phase_low || phase_high) busy++;
        end
        chk(busy == 0, "R1 idle before first write", busy, 0);

        // R4 smallest period, even split
        run_case(0, 0, 0, 0, 2);
        // R2 field placement at the top of both codes, R4 longest period
        run_case(7, 63, 63, 0, 1);
        // R4 odd period: low takes the extra tick
        run_case(2, 3, 1, 0, 2);
        // R6 stretched high phases
        run_case(2, 3, 1, 3, 2);
        run_case(0, 5, 0, 10, 2);

        // R5 write arriving mid-high restarts in the low phase
        run_case(1, 0, 0, 0, 1);
        while (!phase_high) begin
            @(negedge clk);
            #1;
        end
        repeat (3) @(negedge clk);
        run_case(0, 1, 1, 0, 1);

        // randomised codes and stretch lengths
        for (int i = 0; i < 8; i++) begin
            run_case($urandom_range(0, 7), $urandom_range(0, 12),
                     $urandom_range(0, 63), $urandom_range(0, 5), 2);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule